// File: doc/BRIEF.md
# Partial Register Write Merge Unit

This block computes the value a 64-bit general register holds after an instruction writes it at byte, word, double-word or quad-word width. The incoming operand can be copied as it is, widened with zeros, or widened with copies of its sign bit. Two immediate forms are also handled: a 32-bit immediate stretched to 64 bits by sign extension, and a 64-bit immediate loaded whole.

The merge follows an asymmetric rule. Byte and word destinations keep every register bit above the written field. A double-word destination clears bits 63:32. A quad-word destination replaces the whole register.

The merge is purely combinational. A registered shell around it holds a small register file. On a write-enable cycle the shell reads the current value of the selected entry, merges the operand into it, and stores the result. If the width and mode pair is not allowed, the unit raises an error flag and passes the old value through, so the entry is left unchanged. A second index reads any entry combinationally.

Top module: `regmrg_top`

## Requirements
- R1: After reset every register-file entry reads as zero on `rd_val`.
- R2: Width codes are 0 = byte, 1 = word, 2 = double word, 3 = quad word. With a byte destination, bits 7:0 of the result come from the operand and bits 63:8 equal the old value.
- R3: With a word destination, bits 15:0 come from the operand and bits 63:16 equal the old value. This also holds for extending modes.
- R4: With a double-word destination, bits 31:0 come from the operand and bits 63:32 are zero. This also holds for extending modes.
- R5: Mode code 1 (zero extend) pads the operand with zeros. It is legal only for byte→word, byte→dword, byte→qword, word→dword and word→qword. Dword→qword is illegal.
- R6: Mode code 2 (sign extend) fills the bits above the source width with the source's top bit. It is legal for any source narrower than the destination, including dword→qword.
- R7: Mode code 0 (plain copy) is legal only when the source width equals the destination width.
- R8: Mode code 3 requires a double-word source and a quad-word destination, and yields bits 31:0 sign-extended to 64 bits. Mode code 4 requires a quad-word source and destination, and yields all 64 operand bits.
- R9: Any combination not allowed above, including mode codes 5 to 7, raises `bad_combo`. In that case `new_val` equals the old value and the entry keeps its contents.
- R10: When `wr_en` is high at a rising clock, the entry at `wr_sel` takes `new_val`. The entry is readable on `rd_val` from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Commit the merged value this cycle |
| wr_sel | input | 4 | Destination entry index |
| src_val | input | 64 | Operand or immediate value |
| src_sz | input | 2 | Operand width code |
| dst_sz | input | 2 | Destination width code |
| mode | input | 3 | Move mode code |
| rd_sel | input | 4 | Read entry index |
| rd_val | output | 64 | Contents of the entry at `rd_sel` |
| new_val | output | 64 | Merged result for the entry at `wr_sel` |
| bad_combo | output | 1 | Width/mode combination not allowed |

## Verification
The assertions assume that `src_sz`, `dst_sz` and `mode` are stable and known whenever reset is released. They also assume that `new_val` settles from those inputs within the same cycle. Because of this, they check the merged upper bits against the old entry only on cycles where no illegal pairing is flagged. The stimulus changes inputs only on falling edges. It draws every mode code, including the undefined ones, and every width pair, so that illegal pairings occur often and the error path is exercised next to the legal merges.

// File: rtl/regmrg_pkg.sv
// Shared types for the partial register write merge unit.
// Assumes a 64-bit register; width and mode codes are fixed encodings.
package regmrg_pkg;
    localparam int REG_W   = 64;
    localparam int N_SIZES = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_DWRD = 2'd2,
        SZ_QUAD = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        MD_COPY  = 3'd0,
        MD_ZEXT  = 3'd1,
        MD_SEXT  = 3'd2,
        MD_IMM32 = 3'd3,
        MD_IMM64 = 3'd4
    } mode_e;
endpackage

// File: rtl/regmrg_legal.sv
// Decides whether a width/mode pairing is a legal move.
// Assumes the width codes order byte < word < dword < quad.
module regmrg_legal
    import regmrg_pkg::*;
(
    input  size_e       src_sz,
    input  size_e       dst_sz,
    input  logic [2:0]  mode,
    output logic        ok
);
    // Legality table per mode
    always_comb begin
        case (mode)
            MD_COPY:  ok = (src_sz == dst_sz);
            MD_ZEXT:  ok = (src_sz < dst_sz) && (src_sz <= SZ_WORD);
            MD_SEXT:  ok = (src_sz < dst_sz);
            MD_IMM32: ok = (src_sz == SZ_DWRD) && (dst_sz == SZ_QUAD);
            MD_IMM64: ok = (src_sz == SZ_QUAD) && (dst_sz == SZ_QUAD);
            default:  ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/regmrg_extend.sv
// Widens the operand from its source width to the full register width,
// padding with zeros or with its top bit depending on the mode.
// Assumes the caller discards the result for illegal pairings.
module regmrg_extend
    import regmrg_pkg::*;
(
    input  logic [REG_W-1:0] src_val,
    input  size_e            src_sz,
    input  logic [2:0]       mode,
    output logic [REG_W-1:0] ext_val
);
    logic                  use_sign;
    logic [REG_W-1:0]      cand [N_SIZES];

    // Sign padding for sign-extend and the 32-bit immediate form
    always_comb use_sign = (mode == MD_SEXT) || (mode == MD_IMM32);

    // One widened candidate per source width
    for (genvar g = 0; g < N_SIZES; g++) begin : g_cand
        localparam int BW = 8 << g;
        if (BW >= REG_W) begin : g_full
            always_comb cand[g] = src_val;
        end else begin : g_part
            // Pad above the source field
            always_comb cand[g] = {{(REG_W-BW){use_sign & src_val[BW-1]}},
                                   src_val[BW-1:0]};
        end
    end

    // Select the candidate for the given source width
    always_comb ext_val = cand[src_sz];
endmodule

// File: rtl/regmrg_merge.sv
// Combines the widened operand with the old register value by destination
// width: narrow fields keep the old upper bits, dword clears the upper half.
// Falls back to the old value when the pairing is illegal.
module regmrg_merge
    import regmrg_pkg::*;
(
    input  logic [REG_W-1:0] old_val,
    input  logic [REG_W-1:0] ext_val,
    input  size_e            dst_sz,
    input  logic             ok,
    output logic [REG_W-1:0] new_val
);
    logic [REG_W-1:0] merged;

    // Destination-width write-back rule
    always_comb begin
        case (dst_sz)
            SZ_BYTE: merged = {old_val[REG_W-1:8],  ext_val[7:0]};
            SZ_WORD: merged = {old_val[REG_W-1:16], ext_val[15:0]};
            SZ_DWRD: merged = {{(REG_W-32){1'b0}},  ext_val[31:0]};
            default: merged = ext_val;
        endcase
    end

    // Keep the old value on an illegal pairing
    always_comb new_val = ok ? merged : old_val;
endmodule

// File: rtl/regmrg_file.sv
// Register file with one synchronous write port and two combinational
// read ports. Synchronous active-low reset clears every entry.
module regmrg_file
    import regmrg_pkg::*;
#(
    parameter int N_REGS = 16,
    localparam int IDX_W = $clog2(N_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wsel,
    input  logic [REG_W-1:0] wdata,
    input  logic [IDX_W-1:0] asel,
    output logic [REG_W-1:0] adata,
    input  logic [IDX_W-1:0] bsel,
    output logic [REG_W-1:0] bdata
);
    logic [REG_W-1:0] regs_q [N_REGS];

    for (genvar i = 0; i < N_REGS; i++) begin : g_ent
        // Store one entry on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[i] <= '0;
            else if (we && (wsel == IDX_W'(i)))
                regs_q[i] <= wdata;
        end
    end

    // Read port used for the old value
    always_comb adata = regs_q[asel];
    // Read port for external observation
    always_comb bdata = regs_q[bsel];
endmodule

// File: rtl/regmrg_top.sv
// Partial register write merge unit with its register file.
// Reads the destination entry, merges the operand into it by width and
// mode, and stores the result on wr_en. An illegal pairing leaves it as is.
module regmrg_top
    import regmrg_pkg::*;
#(
    parameter int N_REGS = 16,
    localparam int IDX_W = $clog2(N_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_sel,
    input  logic [REG_W-1:0] src_val,
    input  logic [1:0]       src_sz,
    input  logic [1:0]       dst_sz,
    input  logic [2:0]       mode,
    input  logic [IDX_W-1:0] rd_sel,
    output logic [REG_W-1:0] rd_val,
    output logic [REG_W-1:0] new_val,
    output logic             bad_combo
);
    size_e            s_sz, d_sz;
    logic             ok;
    logic [REG_W-1:0] old_val;
    logic [REG_W-1:0] ext_val;

    // Type the width codes
    always_comb begin
        s_sz = size_e'(src_sz);
        d_sz = size_e'(dst_sz);
    end

    regmrg_legal u_legal (
        .src_sz (s_sz),
        .dst_sz (d_sz),
        .mode   (mode),
        .ok     (ok)
    );

    regmrg_extend u_ext (
        .src_val (src_val),
        .src_sz  (s_sz),
        .mode    (mode),
        .ext_val (ext_val)
    );

    regmrg_merge u_merge (
        .old_val (old_val),
        .ext_val (ext_val),
        .dst_sz  (d_sz),
        .ok      (ok),
        .new_val (new_val)
    );

    regmrg_file #(.N_REGS(N_REGS)) u_file (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en & ok),
        .wsel  (wr_sel),
        .wdata (new_val),
        .asel  (wr_sel),
        .adata (old_val),
        .bsel  (rd_sel),
        .bdata (rd_val)
    );

    // Error flag to the port
    always_comb bad_combo = ~ok;
endmodule

// File: rtl/regmrg_chk.sv
// Assertion checker for regmrg_top, attached by bind below.
// Relates the merged result to the old entry value read from the file.
module regmrg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  src_sz,
    input logic [1:0]  dst_sz,
    input logic [2:0]  mode,
    input logic [63:0] old_val,
    input logic [63:0] new_val,
    input logic        bad_combo
);
    // R2
    byte_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bad_combo && dst_sz == 2'd0) |-> (new_val[63:8] == old_val[63:8]));

    // R3
    word_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bad_combo && dst_sz == 2'd1) |-> (new_val[63:16] == old_val[63:16]));

    // R4
    dword_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bad_combo && dst_sz == 2'd2) |-> (new_val[63:32] == 32'd0));

    // R5
    zext_dq_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1 && src_sz == 2'd2 && dst_sz == 2'd3) |-> bad_combo);

    // R9
    bad_keeps_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_combo |-> (new_val == old_val));

    // R9
    undef_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode > 3'd4) |-> bad_combo);
endmodule

bind regmrg_top regmrg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_sz    (src_sz),
    .dst_sz    (dst_sz),
    .mode      (mode),
    .old_val   (old_val),
    .new_val   (new_val),
    .bad_combo (bad_combo)
);

// File: tb/regmrg_top_tb.sv
// Bench for regmrg_top: directed corner cases plus seeded random moves,
// checked against a bench-side model of the register file.
module regmrg_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [63:0] src_val = '0;
    logic [1:0]  src_sz = '0;
    logic [1:0]  dst_sz = '0;
    logic [2:0]  mode = '0;
    logic [3:0]  rd_sel = '0;
    logic [63:0] rd_val, new_val;
    logic        bad_combo;

    int n_run = 0;
    int n_fail = 0;
    logic [63:0] mirror [NR];

    regmrg_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .src_val(src_val), .src_sz(src_sz), .dst_sz(dst_sz), .mode(mode),
        .rd_sel(rd_sel), .rd_val(rd_val), .new_val(new_val),
        .bad_combo(bad_combo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] fmask(input logic [1:0] s);
        return (s == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF
                           : ((64'd1 << (8 << s)) - 64'd1);
    endfunction

    function automatic logic allowed(input logic [2:0] m,
                                     input logic [1:0] s, input logic [1:0] d);
        case (m)
            3'd0: return s == d;
            3'd1: return (s < d) && (s != 2'd2);
            3'd2: return s < d;
            3'd3: return (s == 2'd2) && (d == 2'd3);
            3'd4: return (s == 2'd3) && (d == 2'd3);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [63:0] expect_val(input logic [63:0] old,
            input logic [63:0] src, input logic [1:0] s, input logic [1:0] d,
            input logic [2:0] m);
        logic [63:0] sv, res;
        if (!allowed(m, s, d)) return old;
        sv = src & fmask(s);
        if ((m == 3'd2 || m == 3'd3) && src[(8 << s) - 1]) sv = sv | ~fmask(s);
        res = (old & ~fmask(d)) | (sv & fmask(d));
        if (d == 2'd2) res[63:32] = 32'd0;
        return res;
    endfunction

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] m,
                                     input logic [1:0] s, input logic [1:0] d);
        if (!allowed(m, s, d)) return "R9";
        if (m == 3'd1) return "R5";
        if (m == 3'd2) return "R6";
        if (m >= 3'd3) return "R8";
        if (d == 2'd0) return "R2";
        if (d == 2'd1) return "R3";
        if (d == 2'd2) return "R4";
        return "R7";
    endfunction

    // Apply one move, check the merge, commit, then read the entry back
    task automatic do_move(input logic [3:0] idx, input logic [63:0] v,
            input logic [1:0] s, input logic [1:0] d, input logic [2:0] m);
        logic [63:0] e;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = idx; src_val = v; src_sz = s;
        dst_sz = d; mode = m; rd_sel = idx;
        #1;
        e = expect_val(mirror[idx], v, s, d, m);
        check(tag_of(m, s, d), new_val, e);
        check(allowed(m, s, d) ? "R7" : "R9", {63'd0, bad_combo},
              {63'd0, ~allowed(m, s, d)});
        @(posedge clk);
        mirror[idx] = e;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R10", rd_val, mirror[idx]);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NR; i++) mirror[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < NR; i++) begin
            @(negedge clk); rd_sel = 4'(i); #1;
            check("R1", rd_val, 64'd0);
        end
        // Directed corner cases
        do_move(4'd0, 64'hFFFF_FFFF_1234_5678, 2'd3, 2'd3, 3'd4); // R8 imm64
        do_move(4'd0, 64'h0000_0000_0000_0011, 2'd0, 2'd0, 3'd0); // R2
        do_move(4'd0, 64'h0000_0000_0000_aa55, 2'd1, 2'd1, 3'd0); // R3
        do_move(4'd0, 64'h0000_0000_fedc_ba98, 2'd2, 2'd2, 3'd0); // R4
        do_move(4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 2'd3, 3'd0); // R7
        do_move(4'd1, 64'h0000_0000_0000_80F0, 2'd0, 2'd1, 3'd2); // R3 sext word dst
        do_move(4'd1, 64'h0000_0000_0000_0080, 2'd0, 2'd2, 3'd1); // R4 zext dword dst
        do_move(4'd1, 64'h0000_0000_8000_0001, 2'd2, 2'd3, 3'd2); // R6 dword->qword
        do_move(4'd1, 64'h0000_0000_0000_0001, 2'd2, 2'd3, 3'd1); // R5 illegal
        do_move(4'd2, 64'h1234_5678_FFFF_FFFE, 2'd2, 2'd3, 3'd3); // R8 imm32
        do_move(4'd2, 64'h0000_0000_0000_0005, 2'd3, 2'd3, 3'd3); // R9 bad imm32
        do_move(4'd2, 64'h0000_0000_0000_0005, 2'd1, 2'd0, 3'd2); // R9 narrowing
        do_move(4'd2, 64'h0000_0000_0000_0005, 2'd0, 2'd0, 3'd6); // R9 undef mode
        do_move(4'd3, 64'h0000_0000_0000_8001, 2'd1, 2'd3, 3'd1); // R5 word->qword
        // Seeded random moves over all codes
        for (int k = 0; k < 1500; k++) begin
            do_move(4'($urandom % NR), {$urandom, $urandom},
                    2'($urandom % 4), 2'($urandom % 4), 3'($urandom % 8));
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule